// File: doc/BRIEF.md
# Pixel Blend and Raster-Op Unit

This block merges an incoming ARGB8 source pixel with the destination pixel already in the frame buffer, and produces the pixel that is written back. A single 11-bit operation word selects its behaviour. A 3-bit combine field picks either a 4-bit bitwise logical raster operation or an arithmetic blend. The blend scales the source and the destination by factors chosen from fixed codes, then merges them with saturating add, clamped subtract in either direction, minimum or maximum. All four channels get the same operation.

A per-pixel enable decides whether the unit takes part in fragment processing. When the enable is low the source goes out untouched. A copy-mode input marks pixels taken from a surface that has no stored alpha. In that mode the source alpha is read as zero. The unit is a two-stage pipeline with a valid flag and accepts a new pixel every cycle.

Top module: `pix_blend_rop`

## Requirements
- R1: After reset `out_valid` is low. For each cycle, `out_valid` equals `in_valid` from two clock edges earlier, and back-to-back pixels come out one per cycle in order.
- R2: When `blend_en` is low, `out_px` equals `src_px` bit for bit, whatever the operation word and `copy_mode`.
- R3: When `op_word[10:8]` is 0 the unit is in raster mode. For each bit position, with source bit s and destination bit d, the output bit is `op_word[2*s+d]`. So code 0 clears every bit, code 15 sets every bit, and code 12 copies the source.
- R4: In blend mode, `op_word[7:4]` picks the source factor and `op_word[3:0]` picks the destination factor. The codes are: 0 gives 0, 1 gives 255, 4 gives source alpha, 5 gives 255 minus source alpha, 14 gives the constant alpha `const_px[31:24]`, and 15 gives 255 minus the constant alpha. Every other code gives 0.
- R5: Each channel value x scaled by factor f becomes floor((x*f + 127) / 255).
- R6: Combine code 2 adds the two scaled values and saturates at 255. The unlisted codes 1 and 3 behave the same way.
- R7: Combine code 4 gives scaled source minus scaled destination. Code 5 gives scaled destination minus scaled source. Both clamp at 0.
- R8: Combine code 6 gives the smaller of the two scaled values and code 7 gives the larger.
- R9: When `copy_mode` is high and `blend_en` is high, the source alpha channel `src_px[31:24]` is taken as 0. This holds both for the alpha channel value and for factor codes 4 and 5, in blend mode and in raster mode.
- R10: Channels sit at bits 31:24 (alpha), 23:16, 15:8 and 7:0. Each channel is computed on its own with the same operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| src_px | input | 32 | Source pixel, ARGB8 |
| dst_px | input | 32 | Destination pixel, ARGB8 |
| const_px | input | 32 | Constant blend colour; only its alpha is used |
| op_word | input | 11 | Combine code [10:8], source factor / raster code [7:4] and [3:0] |
| blend_en | input | 1 | Fragment-operation enable for this unit |
| copy_mode | input | 1 | Source has no alpha; read it as zero |
| out_valid | output | 1 | Output pixel qualifier |
| out_px | output | 32 | Resulting pixel |

## Verification
The bench walks all 2048 operation words against several pixel patterns. The patterns include all-ones on both inputs, to force add saturation, and an all-zero source, to force subtract clamping. A design with a wrapping adder would return small values where 255 is expected. A design that underflowed would return values near 255 where 0 is expected. The sweep catches a raster table indexed with source and destination swapped, because codes such as 2 and 4 then trade results. It catches an unlisted factor code leaking a non-zero factor, and rounding that truncates instead of adding 127. Copy-mode patterns with a non-zero source alpha expose a design that still reads the stored alpha. Bubbles in the valid stream expose any latency or ordering error.

// File: rtl/pbr_pkg.sv
`timescale 1ns/1ps
package pbr_pkg;
  localparam int unsigned CH_W   = 8;
  localparam int unsigned PROD_W = 2 * CH_W + 1;
  localparam logic [CH_W-1:0] CH_MAX = {CH_W{1'b1}};

  localparam logic [2:0] CMB_ROP  = 3'd0;
  localparam logic [2:0] CMB_SUB  = 3'd4;
  localparam logic [2:0] CMB_RSUB = 3'd5;
  localparam logic [2:0] CMB_MIN  = 3'd6;
  localparam logic [2:0] CMB_MAX  = 3'd7;

  localparam logic [3:0] FAC_ZERO  = 4'd0;
  localparam logic [3:0] FAC_ONE   = 4'd1;
  localparam logic [3:0] FAC_SA    = 4'd4;
  localparam logic [3:0] FAC_INVSA = 4'd5;
  localparam logic [3:0] FAC_CA    = 4'd14;
  localparam logic [3:0] FAC_INVCA = 4'd15;

  // rounded product of channel and factor, both normalised to full scale
  function automatic logic [CH_W-1:0] scale_ch(input logic [CH_W-1:0] x,
                                               input logic [CH_W-1:0] f);
    logic [PROD_W-1:0] p;
    logic [PROD_W-1:0] q;
    p = PROD_W'(x) * PROD_W'(f) + PROD_W'(CH_MAX >> 1);
    q = p / PROD_W'(CH_MAX);
    return q[CH_W-1:0];
  endfunction

  function automatic logic [CH_W-1:0] combine_ch(input logic [2:0] op,
                                                 input logic [CH_W-1:0] s,
                                                 input logic [CH_W-1:0] d);
    logic [CH_W:0] sum;
    sum = {1'b0, s} + {1'b0, d};
    case (op)
      CMB_SUB:  return (s > d) ? s - d : '0;
      CMB_RSUB: return (d > s) ? d - s : '0;
      CMB_MIN:  return (s < d) ? s : d;
      CMB_MAX:  return (s > d) ? s : d;
      default:  return sum[CH_W] ? CH_MAX : sum[CH_W-1:0];
    endcase
  endfunction

  function automatic logic [CH_W-1:0] rop_ch(input logic [3:0] code,
                                             input logic [CH_W-1:0] s,
                                             input logic [CH_W-1:0] d);
    logic [CH_W-1:0] r;
    for (int i = 0; i < CH_W; i++) r[i] = code[{s[i], d[i]}];
    return r;
  endfunction
endpackage

// File: rtl/pbr_factor_sel.sv
`timescale 1ns/1ps
module pbr_factor_sel
  import pbr_pkg::*;
(
  input  logic [3:0]      code,
  input  logic [CH_W-1:0] src_alpha,
  input  logic [CH_W-1:0] const_alpha,
  output logic [CH_W-1:0] factor
);
  always_comb begin
    case (code)
      FAC_ONE:   factor = CH_MAX;
      FAC_SA:    factor = src_alpha;
      FAC_INVSA: factor = CH_MAX - src_alpha;
      FAC_CA:    factor = const_alpha;
      FAC_INVCA: factor = CH_MAX - const_alpha;
      default:   factor = '0;
    endcase
  end
endmodule

// File: rtl/pbr_channel.sv
`timescale 1ns/1ps
module pbr_channel
  import pbr_pkg::*;
(
  input  logic [2:0]      op,
  input  logic [3:0]      rop_code,
  input  logic [CH_W-1:0] s_val,
  input  logic [CH_W-1:0] d_val,
  input  logic [CH_W-1:0] s_fac,
  input  logic [CH_W-1:0] d_fac,
  output logic [CH_W-1:0] result
);
  logic [CH_W-1:0] s_scaled;
  logic [CH_W-1:0] d_scaled;

  always_comb begin
    s_scaled = scale_ch(s_val, s_fac);
    d_scaled = scale_ch(d_val, d_fac);
    if (op == CMB_ROP) result = rop_ch(rop_code, s_val, d_val);
    else               result = combine_ch(op, s_scaled, d_scaled);
  end
endmodule

// File: rtl/pix_blend_rop.sv
`timescale 1ns/1ps
module pix_blend_rop
  import pbr_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned OPW = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NCH*CH_W-1:0]  src_px,
  input  logic [NCH*CH_W-1:0]  dst_px,
  input  logic [NCH*CH_W-1:0]  const_px,
  input  logic [OPW-1:0]       op_word,
  input  logic                 blend_en,
  input  logic                 copy_mode,
  output logic                 out_valid,
  output logic [NCH*CH_W-1:0]  out_px
);
  localparam int unsigned PX_W  = NCH * CH_W;
  localparam int unsigned A_LSB = PX_W - CH_W;

  // stage 0: effective source and factor decode
  logic [PX_W-1:0] src_eff;
  logic [CH_W-1:0] src_alpha_eff;
  logic [CH_W-1:0] sfac_d;
  logic [CH_W-1:0] dfac_d;

  always_comb begin
    src_eff = src_px;
    if (copy_mode) src_eff[PX_W-1:A_LSB] = '0;
    src_alpha_eff = src_eff[PX_W-1:A_LSB];
  end

  pbr_factor_sel u_sfac (
    .code(op_word[7:4]), .src_alpha(src_alpha_eff),
    .const_alpha(const_px[PX_W-1:A_LSB]), .factor(sfac_d));
  pbr_factor_sel u_dfac (
    .code(op_word[3:0]), .src_alpha(src_alpha_eff),
    .const_alpha(const_px[PX_W-1:A_LSB]), .factor(dfac_d));

  // stage 1 registers
  logic            v1;
  logic            en1;
  logic [2:0]      op1;
  logic [3:0]      rop1;
  logic [PX_W-1:0] raw1;
  logic [PX_W-1:0] s1;
  logic [PX_W-1:0] d1;
  logic [CH_W-1:0] sf1;
  logic [CH_W-1:0] df1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; en1 <= 1'b0; op1 <= '0; rop1 <= '0;
      raw1 <= '0; s1 <= '0; d1 <= '0; sf1 <= '0; df1 <= '0;
    end else begin
      v1   <= in_valid;
      en1  <= blend_en;
      op1  <= op_word[10:8];
      rop1 <= op_word[3:0];
      raw1 <= src_px;
      s1   <= src_eff;
      d1   <= dst_px;
      sf1  <= sfac_d;
      df1  <= dfac_d;
    end
  end

  // stage 1 compute: one lane per channel
  logic [PX_W-1:0] lane_res;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    pbr_channel u_ch (
      .op(op1), .rop_code(rop1),
      .s_val(s1[c*CH_W +: CH_W]), .d_val(d1[c*CH_W +: CH_W]),
      .s_fac(sf1), .d_fac(df1),
      .result(lane_res[c*CH_W +: CH_W]));
  end

  logic [PX_W-1:0] stage1_px;
  assign stage1_px = en1 ? lane_res : raw1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_px    <= '0;
    end else begin
      out_valid <= v1;
      out_px    <= stage1_px;
    end
  end
endmodule

// File: rtl/pbr_chk.sv
`timescale 1ns/1ps
module pbr_chk #(
  parameter int unsigned PX_W = 32,
  parameter int unsigned OPW  = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [PX_W-1:0] src_px,
  input logic [OPW-1:0]  op_word,
  input logic            blend_en,
  input logic            copy_mode,
  input logic            out_valid,
  input logic [PX_W-1:0] out_px
);
  logic            v_a, v_b, en_a, en_b, cp_a, cp_b;
  logic [OPW-1:0]  op_a, op_b;
  logic [PX_W-1:0] s_a, s_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_a <= 1'b0; v_b <= 1'b0; en_a <= 1'b0; en_b <= 1'b0;
      cp_a <= 1'b0; cp_b <= 1'b0; op_a <= '0; op_b <= '0;
      s_a <= '0; s_b <= '0;
    end else begin
      v_a <= in_valid;  v_b <= v_a;
      en_a <= blend_en; en_b <= en_a;
      cp_a <= copy_mode; cp_b <= cp_a;
      op_a <= op_word;  op_b <= op_a;
      s_a <= src_px;    s_b <= s_a;
    end
  end

  logic out_rop;
  assign out_rop = out_valid && en_b && (op_b[10:8] == 3'd0);

  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_b);
  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !en_b) |-> out_px == s_b);
  a_r3_rop_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rop && op_b[3:0] == 4'h0) |-> out_px == '0);
  a_r3_rop_set: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rop && op_b[3:0] == 4'hF) |-> out_px == '1);
  a_r5_unity_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && en_b && !cp_b && op_b == 11'h210) |-> out_px == s_b);
  a_r9_copy_alpha: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rop && cp_b && op_b[3:0] == 4'hC) |-> out_px[PX_W-1 -: 8] == 8'h00);
endmodule

bind pix_blend_rop pbr_chk #(.PX_W(NCH * pbr_pkg::CH_W), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_px(src_px),
  .op_word(op_word), .blend_en(blend_en), .copy_mode(copy_mode),
  .out_valid(out_valid), .out_px(out_px));

// File: tb/sim_pix_blend_rop.sv
`timescale 1ns/1ps
module sim_pix_blend_rop;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src_px = '0, dst_px = '0, const_px = '0;
  logic [10:0] op_word = '0;
  logic        blend_en = 1'b0, copy_mode = 1'b0;
  logic        out_valid;
  logic [31:0] out_px;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  pix_blend_rop u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_px(src_px),
    .dst_px(dst_px), .const_px(const_px), .op_word(op_word),
    .blend_en(blend_en), .copy_mode(copy_mode),
    .out_valid(out_valid), .out_px(out_px));

  function automatic int fac_of(int code, int sa, int ca);
    if (code == 1)  return 255;
    if (code == 4)  return sa;
    if (code == 5)  return 255 - sa;
    if (code == 14) return ca;
    if (code == 15) return 255 - ca;
    return 0;
  endfunction

  function automatic int scl(int x, int f);
    return (x * f + 127) / 255;
  endfunction

  function automatic logic [31:0] model(logic [31:0] s, logic [31:0] d,
      logic [31:0] k, logic [10:0] op, bit en, bit cp);
    logic [31:0] r;
    int sf, df, cmb, sv, dv, a, b, o;
    if (!en) return s;
    if (cp) s[31:24] = 8'h00;
    cmb = int'(op[10:8]);
    sf = fac_of(int'(op[7:4]), int'(s[31:24]), int'(k[31:24]));
    df = fac_of(int'(op[3:0]), int'(s[31:24]), int'(k[31:24]));
    for (int c = 0; c < 4; c++) begin
      sv = int'(s[c*8 +: 8]); dv = int'(d[c*8 +: 8]);
      if (cmb == 0) begin
        o = 0;
        for (int i = 0; i < 8; i++)
          if (((int'(op[3:0]) >> (((sv >> i) & 1) * 2 + ((dv >> i) & 1))) & 1) != 0)
            o += (1 << i);
      end else begin
        a = scl(sv, sf); b = scl(dv, df);
        case (cmb)
          4: o = (a - b < 0) ? 0 : a - b;
          5: o = (b - a < 0) ? 0 : b - a;
          6: o = (a < b) ? a : b;
          7: o = (a > b) ? a : b;
          default: o = (a + b > 255) ? 255 : a + b;
        endcase
      end
      r[c*8 +: 8] = o[7:0];
    end
    return r;
  endfunction

  function automatic string tag_of(logic [10:0] op, bit en, bit cp);
    if (!en) return "R2";
    if (cp) return "R9";
    case (op[10:8])
      3'd0: return "R3";
      3'd4, 3'd5: return "R7";
      3'd6, 3'd7: return "R8";
      default: return "R6";
    endcase
  endfunction

  // two-deep history of driven items
  bit          h1_v = 0, h2_v = 0;
  logic [31:0] h1_e = '0, h2_e = '0;
  string       h1_t = "R1", h2_t = "R1";

  task automatic check_out();
    checks++;
    if (out_valid !== h2_v) begin
      failures++;
      $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, h2_v);
    end else if (h2_v) begin
      checks++;
      if (out_px !== h2_e) begin
        failures++;
        $display("FAIL %s R4 R5 R10 out_px actual=%08h expected=%08h", h2_t, out_px, h2_e);
      end
    end
  endtask

  task automatic drive(bit v, logic [31:0] s, logic [31:0] d, logic [31:0] k,
                       logic [10:0] op, bit en, bit cp);
    @(negedge clk);
    check_out();
    h2_v = h1_v; h2_e = h1_e; h2_t = h1_t;
    in_valid = v; src_px = s; dst_px = d; const_px = k;
    op_word = op; blend_en = en; copy_mode = cp;
    h1_v = v; h1_e = model(s, d, k, op, en, cp); h1_t = tag_of(op, en, cp);
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_px !== 32'h0) begin
      failures++;
      $display("FAIL R1 reset actual=%0b/%08h expected=0/00000000", out_valid, out_px);
    end
    rst_n = 1'b1;
    for (int op = 0; op < 2048; op++) begin
      for (int p = 0; p < 6; p++) begin
        logic [31:0] s, d, k;
        bit v;
        lcg = nxt(lcg); s = lcg;
        lcg = nxt(lcg); d = lcg;
        lcg = nxt(lcg); k = lcg;
        if (p == 0) begin s = 32'hFFFF_FFFF; d = 32'hFFFF_FFFF; end
        if (p == 1) s = 32'h0000_0000;
        if (p == 4) s[31:24] = 8'hC3;
        v = ((op + p) % 7) != 3;
        drive(v, s, d, k, 11'(op), p != 5, p == 4);
      end
    end
    drive(1'b0, '0, '0, '0, '0, 1'b0, 1'b0);
    drive(1'b0, '0, '0, '0, '0, 1'b0, 1'b0);
    drive(1'b0, '0, '0, '0, '0, 1'b0, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule